// File: doc/BRIEF.md
# One-Wire Byte Shift Engine

This block turns a bit-slot engine for a one-wire bus into a byte-wide transfer unit. Software writes a byte to the data address. The engine then issues one slot per bit, least significant bit first. A 1 bit gives a write-1/read slot, whose sampled bus level is shifted into a receive register. A 0 bit gives a write-0 slot. To read a byte, software writes all ones, so every slot samples the bus. The assembled byte is then read back from the same data address.

The bit-slot timing engine sits outside this block and is reached through a request/done handshake. A status word shows four flags: transmit holding empty, transmit shifter empty, receive buffer full and receive shifter full. An enable register picks which of these flags drive the interrupt output. A received byte moves from the shifter into the receive buffer only when the buffer is free. While the shifter holds an unmoved byte, no new transfer starts.

Top module: `owbyte_engine`

## Requirements
- R1: After reset the status word (address 1) reads 0x0C, which is transmit holding empty (bit 2) and transmit shifter empty (bit 3). The interrupt output and the slot request are low.
- R2: A write to the data address (address 0) starts DATA_W slots. Slot i drives slotBit equal to bit i of the byte, starting with bit 0.
- R3: The level sampled in each slot is stored so that the first slot's sample ends up in bit 0 of the received byte. That byte is read from address 0. A write-0 slot on a bus that returns low yields 0 in that position.
- R4: Status bit 2 clears on the cycle after a data write. It sets again on the following cycle, when the byte moves into the idle shifter.
- R5: Status bit 3 clears when a byte is loaded into the shifter. It stays clear while slots are in progress, and sets after the last slot's done.
- R6: Status bit 4 sets when a complete received byte lands in the receive buffer. A read of address 0 clears it.
- R7: Status bit 5 sets when a complete byte stays in the receive shifter because the receive buffer is still full. While bit 5 is set, no new transfer starts, even with a byte pending. Reading the buffer releases the held byte and then the pending transfer.
- R8: slotReq stays high until slotDone is seen. Consecutive slots of one byte follow with no gap in the request.
- R9: irqOut is the OR of the status bits ANDed with the interrupt enable register at address 2. That register reads back what was written.
- R10: A byte written while a transfer is in flight waits in the holding register, with bit 2 clear. Its slots follow directly after the current byte's slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (read side effects) |
| regAddr | input | ADDR_W | Register address: 0 data, 1 status, 2 interrupt enable |
| regWdata | input | DATA_W | Write data |
| regRdata | output | DATA_W | Read data for regAddr (combinational) |
| slotReq | output | 1 | Request one bus slot from the bit-slot engine |
| slotBit | output | 1 | Slot kind: 1 = write-1/read, 0 = write-0 |
| slotDone | input | 1 | One-cycle pulse: current slot finished |
| slotSample | input | 1 | Bus level sampled in the finished slot |
| irqOut | output | 1 | Masked interrupt |

## Verification
The bench builds the block with the default byte width of eight and a modelled slot engine. This engine answers each request after a fixed latency and can be told to hold off. The holding option makes the request-hold rule and the queued second byte observable. Each slot's sample is the slot bit ANDed with a chosen device pattern, so both write-0 and read slots are visible in the received byte. Leaving the receive buffer unread across two transfers brings the receive-shifter-full stall and its release order within reach.

// File: rtl/owbyte_pkg.sv
package owbyte_pkg;
  // status word bit positions (software decodes these)
  localparam int TBE_POS = 2;
  localparam int TSE_POS = 3;
  localparam int RBF_POS = 4;
  localparam int RSF_POS = 5;

  typedef struct packed {
    logic wrTx;
    logic wrIen;
    logic loadShift;
    logic shiftBit;
    logic moveRx;
  } owStrobeT;
endpackage

// File: rtl/owbyte_ctrl.sv
module owbyte_ctrl
  import owbyte_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     wrData,
  input  logic     wrIen,
  input  logic     rdData,
  input  logic     slotDone,
  output owStrobeT strobe,
  output logic     slotReq,
  output logic     txBufEmpty,
  output logic     txShiftEmpty,
  output logic     rxBufFull,
  output logic     rxShiftFull
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(DATA_W - 1);

  logic busy;
  logic [CNT_W-1:0] bitCnt;
  logic lastSlot;

  always_comb begin
    strobe.wrTx      = wrData;
    strobe.wrIen     = wrIen;
    strobe.loadShift = !busy && !txBufEmpty && !rxShiftFull;
    strobe.shiftBit  = busy && slotDone;
    strobe.moveRx    = rxShiftFull && !rxBufFull;
    lastSlot         = strobe.shiftBit && (bitCnt == LAST_SLOT);
  end

  assign slotReq = busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy         <= 1'b0;
      bitCnt       <= '0;
      txBufEmpty   <= 1'b1;
      txShiftEmpty <= 1'b1;
      rxBufFull    <= 1'b0;
      rxShiftFull  <= 1'b0;
    end else begin
      if (strobe.loadShift) begin
        busy         <= 1'b1;
        bitCnt       <= '0;
        txShiftEmpty <= 1'b0;
      end else if (strobe.shiftBit) begin
        bitCnt <= bitCnt + CNT_W'(1);
        if (lastSlot) begin
          busy         <= 1'b0;
          txShiftEmpty <= 1'b1;
        end
      end

      if (wrData)                txBufEmpty <= 1'b0;
      else if (strobe.loadShift) txBufEmpty <= 1'b1;

      if (lastSlot)           rxShiftFull <= 1'b1;
      else if (strobe.moveRx) rxShiftFull <= 1'b0;

      if (strobe.moveRx) rxBufFull <= 1'b1;
      else if (rdData)   rxBufFull <= 1'b0;
    end
  end

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    slotReq && !slotDone |=> slotReq);
  assert_tse_low_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    slotReq |-> !txShiftEmpty);
  assert_load_from_buf_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txShiftEmpty) |-> $past(!txBufEmpty));
  assert_move_rx_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxBufFull) |-> $fell(rxShiftFull));
  assert_stall_R7: assert property (@(posedge clk) disable iff (!rstN)
    rxShiftFull |-> !slotReq);
endmodule

// File: rtl/owbyte_dp.sv
module owbyte_dp
  import owbyte_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  owStrobeT          strobe,
  input  logic [DATA_W-1:0] wdata,
  input  logic              slotSample,
  output logic              slotBit,
  output logic [DATA_W-1:0] rxByte,
  output logic [DATA_W-1:0] ienReg
);
  logic [DATA_W-1:0] txBuf, txShift, rxShift;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txBuf   <= '0;
      txShift <= '0;
      rxShift <= '0;
      rxByte  <= '0;
      ienReg  <= '0;
    end else begin
      if (strobe.wrTx)  txBuf  <= wdata;
      if (strobe.wrIen) ienReg <= wdata;
      if (strobe.loadShift)     txShift <= txBuf;
      else if (strobe.shiftBit) txShift <= txShift >> 1;
      if (strobe.shiftBit) rxShift <= {slotSample, rxShift[DATA_W-1:1]};
      if (strobe.moveRx)   rxByte  <= rxShift;
    end
  end

  assign slotBit = txShift[0];
endmodule

// File: rtl/owbyte_engine.sv
module owbyte_engine
  import owbyte_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 0,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 1,
  parameter logic [ADDR_W-1:0] IEN_ADDR  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              slotReq,
  output logic              slotBit,
  input  logic              slotDone,
  input  logic              slotSample,
  output logic              irqOut
);
  owStrobeT strobe;
  logic tbe, tse, rbf, rsf;
  logic [DATA_W-1:0] rxByte, ienReg, statusVec;
  logic wrData, wrIen, rdData;

  assign wrData = regWrEn && (regAddr == DATA_ADDR);
  assign wrIen  = regWrEn && (regAddr == IEN_ADDR);
  assign rdData = regRdEn && (regAddr == DATA_ADDR);

  owbyte_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrData(wrData), .wrIen(wrIen), .rdData(rdData),
    .slotDone(slotDone), .strobe(strobe), .slotReq(slotReq),
    .txBufEmpty(tbe), .txShiftEmpty(tse), .rxBufFull(rbf), .rxShiftFull(rsf)
  );

  owbyte_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wdata(regWdata),
    .slotSample(slotSample), .slotBit(slotBit), .rxByte(rxByte), .ienReg(ienReg)
  );

  always_comb begin
    statusVec          = '0;
    statusVec[TBE_POS] = tbe;
    statusVec[TSE_POS] = tse;
    statusVec[RBF_POS] = rbf;
    statusVec[RSF_POS] = rsf;
  end

  always_comb begin
    if (regAddr == DATA_ADDR)      regRdata = rxByte;
    else if (regAddr == STAT_ADDR) regRdata = statusVec;
    else if (regAddr == IEN_ADDR)  regRdata = ienReg;
    else                           regRdata = '0;
  end

  assign irqOut = |(statusVec & ienReg);

  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ienReg == '0) |-> !irqOut);
endmodule

// File: tb/owbyte_engine_tb.sv
module owbyte_engine_tb;
  localparam int SLOT_LAT = 3;
  localparam logic [1:0] A_DATA = 2'd0, A_STAT = 2'd1, A_IEN = 2'd2;

  logic clk = 0, rstN = 0;
  logic regWrEn = 0, regRdEn = 0;
  logic [1:0] regAddr = 0;
  logic [7:0] regWdata = 0, regRdata;
  logic slotReq, slotBit, slotDone, slotSample, irqOut;

  int nTests = 0, nFail = 0;
  logic slaveHold = 0;
  logic [7:0] devByte = 8'hFF;
  logic slotLog [0:63];
  int slotCount = 0, latCnt = 0;

  always #4 clk = ~clk;

  owbyte_engine u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .slotReq(slotReq), .slotBit(slotBit), .slotDone(slotDone),
    .slotSample(slotSample), .irqOut(irqOut)
  );

  // slot engine model
  initial begin
    slotDone = 0; slotSample = 0;
    forever begin
      @(negedge clk);
      slotDone = 0;
      if (slotReq && !slaveHold) begin
        if (latCnt == SLOT_LAT) begin
          slotDone = 1;
          slotSample = slotBit & devByte[slotCount % 8];
          slotLog[slotCount % 64] = slotBit;
          slotCount++;
          latCnt = 0;
        end else latCnt++;
      end else latCnt = 0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); regAddr = a; regWdata = d; regWrEn = 1;
    @(negedge clk); regWrEn = 0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); regAddr = a; regRdEn = 1; #1 v = regRdata;
    @(negedge clk); regRdEn = 0;
  endtask

  task automatic peekStat(output logic [7:0] v);
    regAddr = A_STAT; #1 v = regRdata;
  endtask

  task automatic waitStat(input logic [7:0] mask, input logic [7:0] val, input string req);
    logic [7:0] s;
    bit hit = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk); #1 peekStat(s);
      if ((s & mask) == val && !slotReq) begin hit = 1; break; end
    end
    check(hit, req, s, val);
  endtask

  function automatic logic [7:0] logByte(input int base);
    logic [7:0] b;
    for (int i = 0; i < 8; i++) b[i] = slotLog[(base + i) % 64];
    return b;
  endfunction

  task automatic t_reset;
    logic [7:0] s;
    peekStat(s);
    check(s == 8'h0C, "R1 status", s, 8'h0C);
    check(!irqOut && !slotReq, "R1 irq/req", {irqOut, slotReq}, 0);
  endtask

  task automatic t_write;
    logic [7:0] s, v;
    int base = slotCount;
    devByte = 8'h0F;
    wrReg(A_DATA, 8'hA5);
    #1 peekStat(s);
    check(s == 8'h08, "R4 tbe cleared", s, 8'h08);
    @(negedge clk); #1 peekStat(s);
    check(s == 8'h04, "R4/R5 loaded", s, 8'h04);
    check(slotReq == 1, "R2 request", slotReq, 1);
    waitStat(8'h18, 8'h18, "R5 done");
    check(logByte(base) == 8'hA5, "R2 slot order", logByte(base), 8'hA5);
    check(slotCount - base == 8, "R2 slot count", slotCount - base, 8);
    rdReg(A_DATA, v);
    check(v == 8'h05, "R3 write-0 slots", v, 8'h05);
    #1 peekStat(s);
    check(s[4] == 0, "R6 read clears", s, 8'h0C);
  endtask

  task automatic t_read;
    logic [7:0] v;
    devByte = 8'h3C;
    wrReg(A_DATA, 8'hFF);
    waitStat(8'h18, 8'h18, "R6 rbf set");
    rdReg(A_DATA, v);
    check(v == 8'h3C, "R3 read byte", v, 8'h3C);
  endtask

  task automatic t_hold;
    logic [7:0] s;
    int base = slotCount;
    slaveHold = 1;
    devByte = 8'hFF;
    wrReg(A_DATA, 8'h12);
    repeat (20) @(negedge clk);
    check(slotReq == 1, "R8 req held", slotReq, 1);
    wrReg(A_DATA, 8'hE7);
    #1 peekStat(s);
    check(s[2] == 0, "R10 queued tbe", s, 8'h00);
    slaveHold = 0;
    waitStat(8'h3C, 8'h3C, "R10 both done");
    check(logByte(base) == 8'h12, "R10 first byte", logByte(base), 8'h12);
    check(logByte(base + 8) == 8'hE7, "R10 second byte", logByte(base + 8), 8'hE7);
    check(slotCount - base == 16, "R8 slot count", slotCount - base, 16);
    rdReg(A_DATA, s);
    check(s == 8'h12, "R10 rx first", s, 8'h12);
    waitStat(8'h30, 8'h10, "R7 release");
    rdReg(A_DATA, s);
    check(s == 8'hE7, "R10 rx second", s, 8'hE7);
  endtask

  task automatic t_stall;
    logic [7:0] s, v;
    int base;
    devByte = 8'h5A;
    wrReg(A_DATA, 8'hFF);
    waitStat(8'h18, 8'h18, "R6 first");
    devByte = 8'hC3;
    wrReg(A_DATA, 8'hFF);
    waitStat(8'h20, 8'h20, "R7 rsf");
    peekStat(s);
    check(s == 8'h3C, "R7 status full", s, 8'h3C);
    base = slotCount;
    wrReg(A_DATA, 8'h77);
    repeat (10) @(negedge clk);
    #1 peekStat(s);
    check(s == 8'h38 && !slotReq, "R7 stalled", {slotReq, s}, 8'h38);
    check(slotCount == base, "R7 no slots", slotCount - base, 0);
    rdReg(A_DATA, v);
    check(v == 8'h5A, "R7 first byte", v, 8'h5A);
    waitStat(8'h3C, 8'h3C, "R7 third done");
    rdReg(A_DATA, v);
    check(v == 8'hC3, "R7 second byte", v, 8'hC3);
    waitStat(8'h30, 8'h10, "R7 third moved");
    rdReg(A_DATA, v);
    check(v == 8'h43, "R3 third byte", v, 8'h43);
    check(logByte(base) == 8'h77, "R2 third slots", logByte(base), 8'h77);
  endtask

  task automatic t_irq;
    logic [7:0] v;
    wrReg(A_IEN, 8'h10);
    rdReg(A_IEN, v);
    check(v == 8'h10, "R9 ien readback", v, 8'h10);
    check(irqOut == 0, "R9 rbf masked idle", irqOut, 0);
    devByte = 8'h99;
    wrReg(A_DATA, 8'hFF);
    waitStat(8'h18, 8'h18, "R9 xfer");
    check(irqOut == 1, "R9 rbf irq", irqOut, 1);
    rdReg(A_DATA, v);
    #1 check(irqOut == 0, "R9 irq cleared", irqOut, 0);
    wrReg(A_IEN, 8'h04);
    #1 check(irqOut == 1, "R9 tbe irq", irqOut, 1);
    wrReg(A_IEN, 8'h00);
    #1 check(irqOut == 0, "R9 all masked", irqOut, 0);
  endtask

  initial begin
    #(8 * 150000);
    nTests++; nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_write();
    t_read();
    t_hold();
    t_stall();
    t_irq();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule